// File: doc/BRIEF.md
# DMA Submission Register Front End

This block is the software-facing control and status front end of a single-channel DMA engine. Software stages one transfer in a window of 32-bit registers (destination and source address, row length, row count, two strides and a repeat flag) and commits it by writing the start register. The committed request is held in a one-entry submission slot. It is tagged with a rolling 2-bit transfer number, and the slot is offered to the transfer engine through a valid/ready handshake.

The engine reports each finished transfer by its number. The block keeps a per-number done bitmask. It raises a start-of-transfer event when the engine takes the slot, meaning software may submit again. It raises an end-of-transfer event on every completion. Both events are latched in a pending register, gated by a mask, and combined into a single interrupt line. Software reads the transfer number before committing and matches it against the done mask later. Clearing the enable bit aborts everything queued or in flight.

Top module: `dma_submit_regs`

## Requirements
- R1: After reset the slot is empty, the next-ID register (0x404) reads 0, the done mask (0x428) reads 0, pending (0x84) reads 0, the mask (0x80) reads 3 (all masked), control (0x400) reads 0, and `irq`, `req_valid` and `eng_abort` are low.
- R2: The register window decodes the low 12 address bits. Reads of unmapped offsets return 0 and writes to them change nothing. Staging registers read back what was written, truncated to their width: addresses 32 bits, lengths and strides 24 bits.
- R3: Writing a value with bit 0 set to 0x408 while control bit 0 (enable) is 1 and the slot is empty copies the staged fields into the slot, tagged with the current next ID. From the following cycle `req_valid` is high and 0x408 reads 1 until the engine takes the slot.
- R4: A start write is ignored while the slot is occupied or enable is 0. The next ID and the request already in the slot stay unchanged.
- R5: The next ID increments by one, modulo 4, for each accepted commit.
- R6: A handshake (`req_valid` and `req_ready` at a clock edge) empties the slot and sets pending bit 0 (start-of-transfer). It also loads the taken ID into 0x42C and the taken addresses into 0x434 (source) and 0x438 (destination).
- R7: `cpl_valid` with enable set sets done bit `cpl_id` and pending bit 1 (end-of-transfer). A commit clears the done bit of the ID it takes.
- R8: Writing 0x84 clears the pending bits that are 1 in the written value. An event in the same cycle wins over the clear. `irq` is high when any pending bit is set and its mask bit is 0. 0x88 reads pending AND NOT mask.
- R9: While control bit 1 (pause) is set, `req_valid` stays low and the slot keeps its request.
- R10: Writing control with bit 0 = 0 empties the slot, clears the in-flight record and drives `eng_abort` high for the one following cycle. Completions arriving while enable is 0 are ignored.
- R11: Flags bit 0 (0x40C) reaches `req_cyclic`. The lengths written to 0x418 and 0x41C (element count minus one) reach `req_xlen` and `req_ylen` unchanged, and the strides at 0x420 and 0x424 reach the stride outputs unchanged.
- R12: Status (0x430) bit 0 is 1 while the slot is occupied. Bit 1 is 1 while any taken transfer has not yet completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| req_valid | output | 1 | Slot holds a request offered to the engine |
| req_ready | input | 1 | Engine takes the request at this edge |
| req_dst_addr | output | 32 | Destination address |
| req_src_addr | output | 32 | Source address |
| req_xlen | output | 24 | Row length minus one |
| req_ylen | output | 24 | Row count minus one |
| req_dst_stride | output | 24 | Destination row stride |
| req_src_stride | output | 24 | Source row stride |
| req_cyclic | output | 1 | Repeat the request indefinitely |
| req_id | output | 2 | Transfer number of the request |
| cpl_valid | input | 1 | Engine reports a finished transfer |
| cpl_id | input | 2 | Number of the finished transfer |
| eng_abort | output | 1 | One-cycle abort pulse toward the engine |
| irq | output | 1 | Interrupt, any unmasked pending bit |

## Verification
Embedded properties check on every cycle that an occupied slot holds its contents until it is taken or aborted. They also check that each accepted commit steps the ID by one and clears that ID's done bit, that an abort leaves slot and in-flight record empty, that pause keeps the request off the port, and that pending bits rise only on their events and never change without a write or an event. Only the scenarios show the end-to-end properties: the exact fields arriving at the engine after a rejected second commit has overwritten the staging registers, the ID wrap after four transfers, mask and source read-back, abort, and completions being ignored while disabled.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    parameter int ADDR_W = 32;
    parameter int LEN_W  = 24;
    parameter int ID_W   = 2;
    parameter int REG_AW = 12;
    parameter int NIRQ   = 2;

    localparam int NUM_IDS = 1 << ID_W;

    localparam int IRQ_SOT = 0;
    localparam int IRQ_EOT = 1;

    localparam logic [REG_AW-1:0] OFF_IRQ_MASK = 12'h080;
    localparam logic [REG_AW-1:0] OFF_IRQ_PEND = 12'h084;
    localparam logic [REG_AW-1:0] OFF_IRQ_SRC  = 12'h088;
    localparam logic [REG_AW-1:0] OFF_CTRL     = 12'h400;
    localparam logic [REG_AW-1:0] OFF_NEXT_ID  = 12'h404;
    localparam logic [REG_AW-1:0] OFF_START    = 12'h408;
    localparam logic [REG_AW-1:0] OFF_FLAGS    = 12'h40C;
    localparam logic [REG_AW-1:0] OFF_DST      = 12'h410;
    localparam logic [REG_AW-1:0] OFF_SRC      = 12'h414;
    localparam logic [REG_AW-1:0] OFF_XLEN     = 12'h418;
    localparam logic [REG_AW-1:0] OFF_YLEN     = 12'h41C;
    localparam logic [REG_AW-1:0] OFF_DSTRIDE  = 12'h420;
    localparam logic [REG_AW-1:0] OFF_SSTRIDE  = 12'h424;
    localparam logic [REG_AW-1:0] OFF_DONE     = 12'h428;
    localparam logic [REG_AW-1:0] OFF_ACT_ID   = 12'h42C;
    localparam logic [REG_AW-1:0] OFF_STATUS   = 12'h430;
    localparam logic [REG_AW-1:0] OFF_CUR_SRC  = 12'h434;
    localparam logic [REG_AW-1:0] OFF_CUR_DST  = 12'h438;

    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic [LEN_W-1:0]  xlen;
        logic [LEN_W-1:0]  ylen;
        logic [LEN_W-1:0]  dstride;
        logic [LEN_W-1:0]  sstride;
        logic              cyclic;
        logic [ID_W-1:0]   id;
    } xfer_t;

    typedef struct packed {
        logic pause;
        logic enable;
    } ctrl_t;

    function automatic logic [31:0] widen_len(input logic [LEN_W-1:0] v);
        return 32'(v);
    endfunction

endpackage

// File: rtl/dsr_irq.sv
module dsr_irq
    import dsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] evt,
    input  logic            clr_we,
    input  logic [NIRQ-1:0] clr_val,
    input  logic            mask_we,
    input  logic [NIRQ-1:0] mask_val,
    output logic [NIRQ-1:0] pend,
    output logic [NIRQ-1:0] mask,
    output logic            irq
);

    logic [NIRQ-1:0] clr_bits;

    always_comb clr_bits = clr_we ? clr_val : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            mask <= '1;
        end else begin
            pend <= (pend & ~clr_bits) | evt;
            if (mask_we)
                mask <= mask_val;
        end
    end

    assign irq = |(pend & ~mask);

    AST_SOT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[IRQ_SOT]) |-> $past(evt[IRQ_SOT]));  // R6
    AST_EOT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[IRQ_EOT]) |-> $past(evt[IRQ_EOT]));  // R7
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (evt == '0 && !clr_we) |=> $stable(pend));      // R8

endmodule

// File: rtl/dsr_queue.sv
module dsr_queue
    import dsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  logic               abort,
    input  logic               go,
    input  logic               cpl_en,
    input  xfer_t              staged,
    input  logic               req_ready,
    input  logic               cpl_valid,
    input  logic [ID_W-1:0]    cpl_id,
    output xfer_t              slot,
    output logic               slot_full,
    output logic               req_valid,
    output logic               hs,
    output logic [ID_W-1:0]    next_id,
    output logic [NUM_IDS-1:0] done,
    output logic [NUM_IDS-1:0] inflight,
    output logic [ID_W-1:0]    active_id,
    output logic [ADDR_W-1:0]  cur_src,
    output logic [ADDR_W-1:0]  cur_dst
);

    logic [NUM_IDS-1:0] done_nx;
    logic [NUM_IDS-1:0] infl_nx;
    logic               cpl_take;

    assign req_valid = slot_full && go;
    assign hs        = req_valid && req_ready;
    assign cpl_take  = cpl_valid && cpl_en;

    always_comb begin
        done_nx = done;
        if (cpl_take)
            done_nx[cpl_id] = 1'b1;
        if (commit)
            done_nx[next_id] = 1'b0;
    end

    always_comb begin
        infl_nx = inflight;
        if (hs)
            infl_nx[slot.id] = 1'b1;
        if (cpl_take)
            infl_nx[cpl_id] = 1'b0;
        if (abort)
            infl_nx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= '0;
            slot_full <= 1'b0;
            next_id   <= '0;
            done      <= '0;
            inflight  <= '0;
            active_id <= '0;
            cur_src   <= '0;
            cur_dst   <= '0;
        end else begin
            done     <= done_nx;
            inflight <= infl_nx;
            if (abort) begin
                slot_full <= 1'b0;
            end else if (commit) begin
                slot      <= staged;
                slot_full <= 1'b1;
                next_id   <= next_id + 1'b1;
            end else if (hs) begin
                slot_full <= 1'b0;
            end
            if (hs) begin
                active_id <= slot.id;
                cur_src   <= slot.src;
                cur_dst   <= slot.dst;
            end
        end
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (slot_full && !hs && !abort) |=> (slot_full && $stable(slot)));  // R4
    AST_ID_STEP: assert property (@(posedge clk) disable iff (rst)
        commit |=> (next_id == $past(next_id) + 1'b1));                  // R5
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        commit |=> !done[$past(next_id)]);                               // R7
    AST_ABORT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!slot_full && inflight == '0));                       // R10

endmodule

// File: rtl/dma_submit_regs.sv
module dma_submit_regs
    import dsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_dst_addr,
    output logic [ADDR_W-1:0] req_src_addr,
    output logic [LEN_W-1:0]  req_xlen,
    output logic [LEN_W-1:0]  req_ylen,
    output logic [LEN_W-1:0]  req_dst_stride,
    output logic [LEN_W-1:0]  req_src_stride,
    output logic              req_cyclic,
    output logic [ID_W-1:0]   req_id,
    input  logic              cpl_valid,
    input  logic [ID_W-1:0]   cpl_id,
    output logic              eng_abort,
    output logic              irq
);

    ctrl_t              ctrl;
    xfer_t              stage;
    xfer_t              slot;
    logic               slot_full;
    logic               hs;
    logic [ID_W-1:0]    next_id;
    logic [NUM_IDS-1:0] done;
    logic [NUM_IDS-1:0] inflight;
    logic [ID_W-1:0]    active_id;
    logic [ADDR_W-1:0]  cur_src;
    logic [ADDR_W-1:0]  cur_dst;
    logic [NIRQ-1:0]    pend;
    logic [NIRQ-1:0]    mask;
    logic [NIRQ-1:0]    evt;
    logic               commit;
    logic               abort;
    logic               go;

    function automatic logic hit(input logic [REG_AW-1:0] off);
        return bus_wr && (bus_addr == off);
    endfunction

    assign commit = hit(OFF_START) && bus_wdata[0] && ctrl.enable && !slot_full;
    assign abort  = hit(OFF_CTRL) && !bus_wdata[0];
    assign go     = ctrl.enable && !ctrl.pause;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            stage     <= '0;
            eng_abort <= 1'b0;
        end else begin
            eng_abort <= abort;
            if (hit(OFF_CTRL))    ctrl          <= ctrl_t'(bus_wdata[1:0]);
            if (hit(OFF_FLAGS))   stage.cyclic  <= bus_wdata[0];
            if (hit(OFF_DST))     stage.dst     <= bus_wdata[ADDR_W-1:0];
            if (hit(OFF_SRC))     stage.src     <= bus_wdata[ADDR_W-1:0];
            if (hit(OFF_XLEN))    stage.xlen    <= bus_wdata[LEN_W-1:0];
            if (hit(OFF_YLEN))    stage.ylen    <= bus_wdata[LEN_W-1:0];
            if (hit(OFF_DSTRIDE)) stage.dstride <= bus_wdata[LEN_W-1:0];
            if (hit(OFF_SSTRIDE)) stage.sstride <= bus_wdata[LEN_W-1:0];
        end
    end

    xfer_t staged;
    always_comb begin
        staged    = stage;
        staged.id = next_id;
    end

    dsr_queue u_queue (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .abort     (abort),
        .go        (go),
        .cpl_en    (ctrl.enable),
        .staged    (staged),
        .req_ready (req_ready),
        .cpl_valid (cpl_valid),
        .cpl_id    (cpl_id),
        .slot      (slot),
        .slot_full (slot_full),
        .req_valid (req_valid),
        .hs        (hs),
        .next_id   (next_id),
        .done      (done),
        .inflight  (inflight),
        .active_id (active_id),
        .cur_src   (cur_src),
        .cur_dst   (cur_dst)
    );

    always_comb begin
        evt          = '0;
        evt[IRQ_SOT] = hs;
        evt[IRQ_EOT] = cpl_valid && ctrl.enable;
    end

    dsr_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_we   (hit(OFF_IRQ_PEND)),
        .clr_val  (bus_wdata[NIRQ-1:0]),
        .mask_we  (hit(OFF_IRQ_MASK)),
        .mask_val (bus_wdata[NIRQ-1:0]),
        .pend     (pend),
        .mask     (mask),
        .irq      (irq)
    );

    assign req_dst_addr   = slot.dst;
    assign req_src_addr   = slot.src;
    assign req_xlen       = slot.xlen;
    assign req_ylen       = slot.ylen;
    assign req_dst_stride = slot.dstride;
    assign req_src_stride = slot.sstride;
    assign req_cyclic     = slot.cyclic;
    assign req_id         = slot.id;

    always_comb begin
        case (bus_addr)
            OFF_IRQ_MASK: bus_rdata = 32'(mask);
            OFF_IRQ_PEND: bus_rdata = 32'(pend);
            OFF_IRQ_SRC:  bus_rdata = 32'(pend & ~mask);
            OFF_CTRL:     bus_rdata = 32'(ctrl);
            OFF_NEXT_ID:  bus_rdata = 32'(next_id);
            OFF_START:    bus_rdata = 32'(slot_full);
            OFF_FLAGS:    bus_rdata = 32'(stage.cyclic);
            OFF_DST:      bus_rdata = 32'(stage.dst);
            OFF_SRC:      bus_rdata = 32'(stage.src);
            OFF_XLEN:     bus_rdata = widen_len(stage.xlen);
            OFF_YLEN:     bus_rdata = widen_len(stage.ylen);
            OFF_DSTRIDE:  bus_rdata = widen_len(stage.dstride);
            OFF_SSTRIDE:  bus_rdata = widen_len(stage.sstride);
            OFF_DONE:     bus_rdata = 32'(done);
            OFF_ACT_ID:   bus_rdata = 32'(active_id);
            OFF_STATUS:   bus_rdata = {30'd0, |inflight, slot_full};
            OFF_CUR_SRC:  bus_rdata = 32'(cur_src);
            OFF_CUR_DST:  bus_rdata = 32'(cur_dst);
            default:      bus_rdata = 32'd0;
        endcase
    end

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ctrl.pause |-> !req_valid);  // R9

endmodule

// File: tb/test_dma_submit_regs.sv
module test_dma_submit_regs;
    import dsr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [REG_AW-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [ADDR_W-1:0] req_dst_addr, req_src_addr;
    logic [LEN_W-1:0]  req_xlen, req_ylen, req_dst_stride, req_src_stride;
    logic              req_cyclic;
    logic [ID_W-1:0]   req_id;
    logic              cpl_valid = 1'b0;
    logic [ID_W-1:0]   cpl_id = '0;
    logic              eng_abort;
    logic              irq;

    always #10 clk = ~clk;

    dma_submit_regs i_dma_submit_regs (.*);

    int n_chk  = 0;
    int n_fail = 0;
    logic [ID_W-1:0] model_id = '0;
    logic [31:0] v;

    typedef struct {
        logic [31:0] dst, src, xl, yl, ds, ss;
        logic        cyc;
        logic [1:0]  id;
    } exp_t;
    exp_t sb[$];
    exp_t e;

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string rq, input logic [REG_AW-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(rq, d, exp);
    endtask

    // Stage and commit; an accepted commit becomes a scoreboard entry.
    task automatic commit(input logic [31:0] dst, input logic [31:0] src,
                          input logic [31:0] xl, input logic [31:0] yl,
                          input logic cyc, input logic accepted);
        exp_t x;
        wr(OFF_DST, dst);
        wr(OFF_SRC, src);
        wr(OFF_XLEN, xl);
        wr(OFF_YLEN, yl);
        wr(OFF_DSTRIDE, xl + 32'd1);
        wr(OFF_SSTRIDE, xl + 32'd9);
        wr(OFF_FLAGS, {31'd0, cyc});
        wr(OFF_START, 32'd1);
        if (accepted) begin
            x.dst = dst; x.src = src; x.xl = xl; x.yl = yl;
            x.ds = xl + 32'd1; x.ss = xl + 32'd9; x.cyc = cyc; x.id = model_id;
            sb.push_back(x);
            model_id = model_id + 1'b1;
        end
    endtask

    task automatic take();
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
    endtask

    task automatic complete(input logic [ID_W-1:0] id);
        @(negedge clk); cpl_valid = 1'b1; cpl_id = id;
        @(negedge clk); cpl_valid = 1'b0;
    endtask

    // Monitor: every handshake must match the oldest expected request.
    always @(negedge clk) begin
        #2;
        if (!rst && req_valid && req_ready) begin
            if (sb.size() == 0) begin
                check("R6 unexpected handshake", 32'd1, 32'd0);
            end else begin
                e = sb.pop_front();
                check("R3 dst addr", req_dst_addr, e.dst);
                check("R3 src addr", req_src_addr, e.src);
                check("R11 xlen", widen_len(req_xlen), e.xl);
                check("R11 ylen", widen_len(req_ylen), e.yl);
                check("R11 dst stride", widen_len(req_dst_stride), e.ds);
                check("R11 src stride", widen_len(req_src_stride), e.ss);
                check("R11 cyclic", 32'(req_cyclic), 32'(e.cyc));
                check("R3 id", 32'(req_id), 32'(e.id));
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 next id", OFF_NEXT_ID, 32'd0);
        rd_chk("R1 mask", OFF_IRQ_MASK, 32'd3);
        rd_chk("R1 pending", OFF_IRQ_PEND, 32'd0);
        rd_chk("R1 start", OFF_START, 32'd0);
        rd_chk("R1 done", OFF_DONE, 32'd0);
        rd_chk("R1 ctrl", OFF_CTRL, 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 req_valid", 32'(req_valid), 32'd0);
        check("R1 abort", 32'(eng_abort), 32'd0);

        // R2 unmapped and staging readback
        wr(12'h100, 32'hDEADBEEF);
        rd_chk("R2 unmapped", 12'h100, 32'd0);
        wr(OFF_XLEN, 32'hFF12_3456);
        rd_chk("R2 length truncation", OFF_XLEN, 32'h0012_3456);

        // R3/R5 first commit
        wr(OFF_CTRL, 32'd1);
        commit(32'h1000, 32'h2000, 32'd63, 32'd0, 1'b0, 1'b1);
        rd_chk("R3 start busy", OFF_START, 32'd1);
        rd_chk("R5 next id", OFF_NEXT_ID, 32'd1);
        check("R3 req_valid", 32'(req_valid), 32'd1);
        rd_chk("R12 status slot", OFF_STATUS, 32'd1);

        // R4 commit while occupied is ignored (monitor later sees first fields)
        commit(32'h3000, 32'h4000, 32'd5, 32'd5, 1'b1, 1'b0);
        rd_chk("R4 id unchanged when full", OFF_NEXT_ID, 32'd1);

        // R9 pause
        wr(OFF_CTRL, 32'd3);
        check("R9 paused valid", 32'(req_valid), 32'd0);
        rd_chk("R9 slot kept", OFF_START, 32'd1);
        wr(OFF_CTRL, 32'd1);
        check("R9 resumed valid", 32'(req_valid), 32'd1);

        // R6 handshake
        wr(OFF_IRQ_MASK, 32'd0);
        take();
        check("R6 scoreboard drained", 32'(sb.size()), 32'd0);
        rd_chk("R6 sot pending", OFF_IRQ_PEND, 32'd1);
        check("R8 irq unmasked", 32'(irq), 32'd1);
        rd_chk("R6 active id", OFF_ACT_ID, 32'd0);
        rd_chk("R6 current dst", OFF_CUR_DST, 32'h1000);
        rd_chk("R6 current src", OFF_CUR_SRC, 32'h2000);
        rd_chk("R12 status in flight", OFF_STATUS, 32'd2);

        // R8 clear
        wr(OFF_IRQ_PEND, 32'd1);
        rd_chk("R8 pending cleared", OFF_IRQ_PEND, 32'd0);
        check("R8 irq low", 32'(irq), 32'd0);

        // R7 completion
        complete(2'd0);
        rd_chk("R7 done bit", OFF_DONE, 32'd1);
        rd_chk("R7 eot pending", OFF_IRQ_PEND, 32'd2);
        rd_chk("R12 status idle", OFF_STATUS, 32'd0);
        wr(OFF_IRQ_PEND, 32'd2);

        for (int k = 1; k < 4; k++) begin
            commit(32'h1000 + 32'(k) * 32'h100, 32'h8000 + 32'(k), 32'(k), 32'(k), 1'b0, 1'b1);
            take();
            complete(2'(k));
        end
        rd_chk("R7 all done", OFF_DONE, 32'hF);
        rd_chk("R5 id wrap", OFF_NEXT_ID, 32'd0);

        // R7 reuse clears done; R11 cyclic
        commit(32'hA000, 32'hB000, 32'd15, 32'd7, 1'b1, 1'b1);
        rd_chk("R7 reuse clears done", OFF_DONE, 32'hE);
        take();
        check("R11 scoreboard drained", 32'(sb.size()), 32'd0);

        // R8 mask and source
        wr(OFF_IRQ_MASK, 32'd3);
        check("R8 irq masked", 32'(irq), 32'd0);
        rd_chk("R8 source masked", OFF_IRQ_SRC, 32'd0);
        wr(OFF_IRQ_MASK, 32'd1);
        rd_chk("R8 source partial", OFF_IRQ_SRC, 32'd2);
        check("R8 irq partial", 32'(irq), 32'd1);

        // R10 abort
        commit(32'hC000, 32'hD000, 32'd3, 32'd0, 1'b0, 1'b1);
        wr(OFF_CTRL, 32'd0);
        check("R10 abort pulse", 32'(eng_abort), 32'd1);
        @(negedge clk);
        check("R10 abort one cycle", 32'(eng_abort), 32'd0);
        void'(sb.pop_back());
        check("R10 req_valid", 32'(req_valid), 32'd0);
        rd_chk("R10 slot empty", OFF_START, 32'd0);
        rd_chk("R10 status cleared", OFF_STATUS, 32'd0);
        complete(2'd0);
        rd_chk("R10 completion ignored", OFF_DONE, 32'hC);

        // R4 commit while disabled
        commit(32'hE000, 32'hF000, 32'd1, 32'd0, 1'b0, 1'b0);
        rd_chk("R4 id unchanged when disabled", OFF_NEXT_ID, 32'd2);
        rd_chk("R4 slot empty when disabled", OFF_START, 32'd0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule